// File: doc/BRIEF.md
# I2C Bus Idle Watchdog and Stuck-Bus Recovery

This block watches the sampled SCL and SDA levels of an I2C bus and measures how long the bus has been quiet. The measurement runs on a clock-enable tick. Any edge on either line restarts it. When the quiet time reaches its limit, the block looks at SDA. If SDA is high, the bus is idle and the block raises a bus-free flag. If SDA is low, a target is holding the bus, so the block requests SCL low and releases it again to clock out nine pulses. It stops early once SDA reads high.

Two timeout lengths are available, a long one and a short one, selected by a speed-up input. Both are given as parameters in ticks. A disable input stops the watchdog from expiring and from starting a recovery. The block also delays the local SDA drive-low request before it reaches the pin driver. A 2-bit code sets the delay, and each code step adds a fixed number of base clock cycles on top of a minimum. The defaults are 12 cycles (240 ns at 50 MHz) plus 2 cycles (40 ns) per step.

Top module: `i2c_bus_guard`

## Requirements
- R1: An edge on scl_i or sda_i restarts the idle count. Activity with gaps shorter than the selected timeout never sets bus_free_o and never starts recovery.
- R2: The timeout is LONG_TICKS ticks when wd_fast_i is 0 and SHORT_TICKS ticks when it is 1. Only cycles with tick_i high count. With tick_i at 1 every cycle, the action takes effect on the limit-th clock edge after the edge that sees the last line change.
- R3: While wd_disable_i is 1, no timeout occurs. bus_free_o does not rise and recovery does not start, whatever the SDA level.
- R4: A timeout with sda_i high sets bus_free_o to 1, and scl_drive_low_o stays 0.
- R5: A timeout with sda_i low raises recov_active_o on the same edge. Each recovery pulse holds scl_drive_low_o at 1 for HALF_TICKS ticks, then at 0 for HALF_TICKS ticks. scl_drive_low_o is never 1 outside recovery.
- R6: If SDA stays low, recovery produces exactly NUM_PULSES (default 9) pulses, ends with SCL released, and leaves bus_free_o at 0. The idle count then starts again from zero, so the next recovery begins one full timeout later.
- R7: If sda_i is high at the end of a pulse's released half, recovery stops after that pulse and bus_free_o is set to 1.
- R8: The first edge on scl_i or sda_i outside recovery clears bus_free_o on that clock edge. Edges seen during recovery do not clear it and do not restart the count.
- R9: A change of sda_req_i reaches sda_drive_low_o DLY_BASE_CYC + code*DLY_STEP_CYC clock cycles after the edge that first sees it. The code is sda_dly_sel_i (2-bit, 0..3), sampled when the change is seen.
- R10: After reset, bus_free_o, recov_active_o, scl_drive_low_o and sda_drive_low_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick for the watchdog and pulse timing |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| wd_disable_i | input | 1 | 1 stops the watchdog from expiring |
| wd_fast_i | input | 1 | 1 selects the short timeout |
| sda_dly_sel_i | input | 2 | SDA output delay code |
| sda_req_i | input | 1 | Local request to pull SDA low |
| bus_free_o | output | 1 | Bus judged idle and free |
| recov_active_o | output | 1 | Recovery pulse sequence running |
| scl_drive_low_o | output | 1 | Request to pull SCL low |
| sda_drive_low_o | output | 1 | Delayed SDA pull-low request |

## Verification
The timeout is first tried with SDA high and then with SDA held low, which separates the bus-free decision from the recovery decision. Holding SDA low through all nine pulses is then compared with releasing it after the third pulse, which separates a full recovery followed by a restart from an early stop that frees the bus. Random bursts of activity with gaps just under the limit show that edges restart the count. A stretch with tick_i low, and a stretch with the disable input set, show that only ticks count and that the disable input blocks every action. Each of the four delay codes, and then random codes and request toggles, check the exact cycle on which the delayed SDA request moves.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOW, SEQ_HIGH} seq_state_e;

  function automatic int unsigned hold_cycles(int unsigned base, int unsigned step, logic [1:0] code);
    return base + int'(code) * step;
  endfunction
endpackage

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
  parameter int unsigned LONG_TICKS  = 1000000,
  parameter int unsigned SHORT_TICKS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  input  logic hold_i,
  input  logic restart_i,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          expired_q;
  logic [CW-1:0] lim_m1;
  logic          run;

  assign lim_m1    = fast_i ? CW'(SHORT_TICKS - 1) : CW'(LONG_TICKS - 1);
  assign run       = !expired_q && !hold_i;
  assign timeout_o = run && tick_i && !restart_i && (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (hold_i || restart_i) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (timeout_o) begin
      cnt_q     <= '0;
      expired_q <= 1'b1;
    end else if (run && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // one action per quiet period
  assert_single_timeout_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

// File: rtl/i2c_recov_seq.sv
module i2c_recov_seq
  import i2c_guard_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 5,
  parameter int unsigned NUM_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic sda_i,
  output logic active_o,
  output logic scl_low_o,
  output logic freed_o
);
  localparam int unsigned HW = $clog2(HALF_TICKS + 1);
  localparam int unsigned PW = $clog2(NUM_PULSES + 1);

  seq_state_e    state_q;
  logic [HW-1:0] hcnt_q;
  logic [PW-1:0] pcnt_q;
  logic          half_end;

  assign half_end  = tick_i && (hcnt_q == HW'(HALF_TICKS - 1));
  assign active_o  = (state_q != SEQ_IDLE);
  assign scl_low_o = (state_q == SEQ_LOW);
  assign freed_o   = (state_q == SEQ_HIGH) && half_end && sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      hcnt_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_LOW;
          hcnt_q  <= '0;
          pcnt_q  <= '0;
        end
        SEQ_LOW: if (half_end) begin
          state_q <= SEQ_HIGH;
          hcnt_q  <= '0;
        end else if (tick_i) begin
          hcnt_q <= hcnt_q + 1'b1;
        end
        SEQ_HIGH: if (half_end) begin
          hcnt_q <= '0;
          pcnt_q <= pcnt_q + 1'b1;
          // SCL has been released for a full half already: no self-made edge on exit
          if (sda_i || pcnt_q == PW'(NUM_PULSES - 1)) state_q <= SEQ_IDLE;
          else                                        state_q <= SEQ_LOW;
        end else if (tick_i) begin
          hcnt_q <= hcnt_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_pulse_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= PW'(NUM_PULSES));
  assert_exit_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(state_q) == SEQ_HIGH);
endmodule

// File: rtl/i2c_sda_delay.sv
module i2c_sda_delay
  import i2c_guard_pkg::*;
#(
  parameter int unsigned BASE_CYC = 12,
  parameter int unsigned STEP_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       req_i,
  output logic       out_o
);
  localparam int unsigned CW = $clog2(BASE_CYC + 3 * STEP_CYC + 1);

  logic [CW-1:0] cnt_q, tgt_q;
  logic          busy_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tgt_q  <= '0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      out_o  <= 1'b0;
    end else if (!busy_q) begin
      if (req_i != out_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
        pend_q <= req_i;
        tgt_q  <= CW'(hold_cycles(BASE_CYC, STEP_CYC, sel_i));
      end
    end else if (cnt_q == tgt_q) begin
      out_o  <= pend_q;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_out_after_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> $past(busy_q && cnt_q == tgt_q));
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard #(
  parameter int unsigned LONG_TICKS   = 1000000,
  parameter int unsigned SHORT_TICKS  = 50000,
  parameter int unsigned HALF_TICKS   = 5,
  parameter int unsigned NUM_PULSES   = 9,
  parameter int unsigned DLY_BASE_CYC = 12,
  parameter int unsigned DLY_STEP_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wd_disable_i,
  input  logic       wd_fast_i,
  input  logic [1:0] sda_dly_sel_i,
  input  logic       sda_req_i,
  output logic       bus_free_o,
  output logic       recov_active_o,
  output logic       scl_drive_low_o,
  output logic       sda_drive_low_o
);
  logic scl_q, sda_q;
  logic activity, timeout, freed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign activity = (scl_i ^ scl_q) | (sda_i ^ sda_q);

  i2c_idle_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .fast_i    (wd_fast_i),
    .hold_i    (wd_disable_i | recov_active_o),
    .restart_i (activity),
    .timeout_o (timeout)
  );

  i2c_recov_seq #(.HALF_TICKS(HALF_TICKS), .NUM_PULSES(NUM_PULSES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (timeout & ~sda_i),
    .sda_i     (sda_i),
    .active_o  (recov_active_o),
    .scl_low_o (scl_drive_low_o),
    .freed_o   (freed)
  );

  i2c_sda_delay #(.BASE_CYC(DLY_BASE_CYC), .STEP_CYC(DLY_STEP_CYC)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sda_dly_sel_i),
    .req_i  (sda_req_i),
    .out_o  (sda_drive_low_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              bus_free_o <= 1'b0;
    else if (activity && !recov_active_o)     bus_free_o <= 1'b0;
    else if ((timeout && sda_i) || freed)     bus_free_o <= 1'b1;
  end

  assert_drive_in_recov_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_drive_low_o |-> recov_active_o);
  assert_free_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_free_o && recov_active_o));
  assert_edge_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity && !recov_active_o) |=> !bus_free_o);
  assert_disable_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_disable_i && !recov_active_o) |=> (!recov_active_o && !$rose(bus_free_o)));
endmodule

// File: tb/i2c_bus_guard_tb.sv
module i2c_bus_guard_tb;
  localparam int LONG  = 120;
  localparam int SHORT = 30;
  localparam int HALF  = 4;
  localparam int NP    = 9;
  localparam int BASE  = 12;
  localparam int STEP  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic scl_ext = 1'b1, sda_ext = 1'b1;
  logic dis = 1'b0, fast = 1'b0;
  logic [1:0] sel = 2'd0;
  logic req = 1'b0;
  logic bus_free, recov, scl_drv, sda_drv;
  logic scl_w, sda_w;

  assign scl_w = scl_ext & ~scl_drv;
  assign sda_w = sda_ext;

  always #10 clk = ~clk;

  i2c_bus_guard #(
    .LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .HALF_TICKS(HALF), .NUM_PULSES(NP),
    .DLY_BASE_CYC(BASE), .DLY_STEP_CYC(STEP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .scl_i(scl_w), .sda_i(sda_w),
    .wd_disable_i(dis), .wd_fast_i(fast), .sda_dly_sel_i(sel), .sda_req_i(req),
    .bus_free_o(bus_free), .recov_active_o(recov), .scl_drive_low_o(scl_drv),
    .sda_drive_low_o(sda_drv)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // pulse monitor
  int pulse_cnt = 0, low_run = 0, last_low_w = 0;
  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (scl_drv && !drv_prev) pulse_cnt++;
    if (scl_drv) low_run++;
    else if (drv_prev) begin last_low_w = low_run; low_run = 0; end
    drv_prev = scl_drv;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_delay(input logic [1:0] code);
    return BASE + int'(code) * STEP;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, len;
    void'($urandom(32'd4711));
    waitn(2);
    // R10 reset state
    chk({bus_free, recov, scl_drv, sda_drv} == 4'b0, "R10 reset outputs",
        int'({bus_free, recov, scl_drv, sda_drv}), 0);
    rst_n = 1'b1;
    waitn(2);

    // R4 + R2 slow timeout with SDA high
    sda_ext = 1'b0; waitn(1); sda_ext = 1'b1;
    waitn(LONG);
    chk(bus_free == 1'b0, "R2 no free before long limit", bus_free, 0);
    waitn(1);
    chk(bus_free == 1'b1, "R4 free at long limit", bus_free, 1);
    chk(scl_drv == 1'b0 && recov == 1'b0, "R4 no scl drive", int'(scl_drv), 0);

    // R8 first edge clears free
    scl_ext = 1'b0; waitn(1);
    chk(bus_free == 1'b0, "R8 edge clears free", bus_free, 0);
    scl_ext = 1'b1;

    // R2 fast timeout
    fast = 1'b1;
    waitn(1); sda_ext = 1'b0; waitn(1); sda_ext = 1'b1;
    waitn(SHORT);
    chk(bus_free == 1'b0, "R2 no free before short limit", bus_free, 0);
    waitn(1);
    chk(bus_free == 1'b1, "R2 free at short limit", bus_free, 1);

    // R2 only ticks count
    tick = 1'b0;
    scl_ext = 1'b0; waitn(1); scl_ext = 1'b1; waitn(1);
    waitn(LONG * 2);
    chk(bus_free == 1'b0, "R2 no ticks no timeout", bus_free, 0);
    tick = 1'b1;
    waitn(SHORT - 1);
    chk(bus_free == 1'b0, "R2 ticks resumed before limit", bus_free, 0);
    waitn(1);
    chk(bus_free == 1'b1, "R2 ticks resumed at limit", bus_free, 1);

    // R3 disable, SDA high then SDA low
    dis = 1'b1;
    scl_ext = 1'b0; waitn(1); scl_ext = 1'b1;
    waitn(LONG * 2);
    chk(bus_free == 1'b0, "R3 disabled no free", bus_free, 0);
    p0 = pulse_cnt;
    sda_ext = 1'b0;
    waitn(LONG * 2);
    chk(recov == 1'b0 && pulse_cnt == p0, "R3 disabled no recovery", pulse_cnt - p0, 0);

    // R5 recovery start after disable released
    dis = 1'b0;
    waitn(SHORT - 1);
    chk(recov == 1'b0, "R5 recovery not yet", recov, 0);
    waitn(1);
    chk(recov == 1'b1, "R5 recovery starts at limit", recov, 1);

    // R6 full sequence with SDA stuck low
    len = 1;
    while (recov && len < 1000) begin
      @(negedge clk);
      if (recov) len++;
    end
    chk(len == 2 * HALF * NP, "R6 recovery duration", len, 2 * HALF * NP);
    chk(pulse_cnt - p0 == NP, "R6 pulse count", pulse_cnt - p0, NP);
    chk(last_low_w == HALF, "R5 low half width", last_low_w, HALF);
    chk(bus_free == 1'b0 && scl_drv == 1'b0, "R6 released not free", bus_free, 0);
    waitn(SHORT - 1);
    chk(recov == 1'b0, "R6 restart not early", recov, 0);
    waitn(1);
    chk(recov == 1'b1, "R6 second recovery after timeout", recov, 1);

    // R7 early stop after third pulse
    p0 = pulse_cnt - 1;
    while (pulse_cnt - p0 < 3) @(negedge clk);
    sda_ext = 1'b1;
    while (recov) @(negedge clk);
    chk(pulse_cnt - p0 == 3, "R7 stopped after pulse 3", pulse_cnt - p0, 3);
    chk(bus_free == 1'b1, "R7 free after early stop", bus_free, 1);
    waitn(3);
    chk(bus_free == 1'b1, "R8 recovery edges ignored", bus_free, 1);

    // R1 random activity just under the limit
    scl_ext = 1'b0; waitn(1);
    for (int i = 0; i < 25; i++) begin
      int g;
      g = 1 + int'($urandom % (SHORT - 1));
      waitn(g);
      chk(bus_free == 1'b0 && recov == 1'b0, "R1 activity keeps bus busy", bus_free, 0);
      if ($urandom % 2) scl_ext = ~scl_ext;
      else              sda_ext = ~sda_ext;
    end
    scl_ext = 1'b1; sda_ext = 1'b1;
    dis = 1'b1;

    // R9 delay, every code then random
    for (int i = 0; i < 16; i++) begin
      int n;
      logic old;
      sel = (i < 4) ? 2'(i) : 2'($urandom % 4);
      n = exp_delay(sel);
      old = sda_drv;
      req = ~req;
      waitn(n);
      chk(sda_drv == old, "R9 delay not early", sda_drv, old);
      waitn(1);
      chk(sda_drv == req, "R9 delay arrival", sda_drv, req);
      waitn(1 + int'($urandom % 5));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule